// File: doc/BRIEF.md
# Subrate Bit-Level TDM Switch

This block routes single bits between 8-bit PCM time slots. A frame of `SLOTS` byte-wide time slots enters one slot per clock. A frame pulse marks slot 0. Each bit position inside a slot is an 8 kbps subchannel, so a 64 kbps slot carries eight of them. Any output subchannel can take its value from any input subchannel. One source may feed several outputs. A wider connection of N × 8 kbps is a run of N subchannels that are routed together.

The incoming frame is written into one half of a two-bank frame store. The outgoing frame is assembled from the other half, which holds the frame before. The banks swap on every frame pulse. Every path therefore has exactly one frame of delay, and grouped subchannels keep their order. A control port writes a shadow copy of the routing table. The shadow is copied into the active table at the next frame pulse, so a single output frame never mixes old and new routes.

Top module: `subrate_bit_switch`

## Requirements
- R1: While reset is low and after it is released, `out_data` is 8'hFF and `out_fsync` is 0. Every route starts invalid.
- R2: `fsync` high marks input slot 0, and each later clock advances the slot by one. After slot `SLOTS`-1 the count wraps to 0 even when no `fsync` arrives. A wrap without `fsync` does not swap the banks.
- R3: The output for slot s is registered on the clock edge that takes in input slot s. It is visible one cycle later, and `out_fsync` follows `fsync` with the same one-cycle lag.
- R4: Each output frame is built only from the input frame that was completed at the `fsync` that opened it. This gives a fixed one-frame delay for every path.
- R5: Output subchannel (b, d) carries input subchannel (a, c) of the previous frame when its route entry is valid and names slot a and subchannel c. Any number of outputs may share one source.
- R6: Subchannel k of a slot is byte bit 7-k. Subchannel 0 is the MSB and is sent first.
- R7: An output subchannel whose entry is invalid, or whose source slot is `SLOTS` or higher, outputs 1.
- R8: A control write with `cfg_we` high stores {`cfg_valid`, `cfg_src_slot`, `cfg_src_sub`} for output address `cfg_addr` = out_slot*8 + out_subchannel. Addresses whose slot field is `SLOTS` or higher are ignored.
- R9: A written route applies from the first output frame whose `fsync` comes strictly after the write. A write made on the `fsync` cycle waits for the following frame.
- R10: A group of consecutive subchannels that crosses a slot boundary keeps its order and alignment at the output.
- R11: The write bank toggles on every `fsync` and holds at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one time slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | High with input slot 0 of a frame |
| in_data | input | 8 | Input slot byte, bit 7 = subchannel 0 |
| cfg_we | input | 1 | Route write strobe |
| cfg_addr | input | SLOT_W+3 | Output address {out_slot, out_subchannel} |
| cfg_valid | input | 1 | Route enable for the written entry |
| cfg_src_slot | input | SLOT_W | Source slot of the route |
| cfg_src_sub | input | 3 | Source subchannel of the route |
| out_data | output | 8 | Output slot byte, one cycle after the input slot |
| out_fsync | output | 1 | High with output slot 0 |

## Verification
The hardest case to reach from the ports is the frame boundary. There, a route written on the very cycle of `fsync` must stay out of the new frame, while the output for slot 0 must already use routes written just before. The bench reaches this case by scheduling writes on the pulse cycle itself and on the last slot before it. It also runs a frame whose count wraps with no pulse. Random routes are drawn over the full source-slot field, so they include slots beyond `SLOTS` and many outputs that share one source. A reference model that tracks the shadow table, the active table and the previous frame predicts every output byte.

// File: rtl/sbs_pkg.sv
// Shared constants for the subrate bit switch.
// Assumes byte-wide slots of eight 8 kbps subchannels each.
package sbs_pkg;
    localparam int SUBCH = 8;
    localparam int SUB_W = 3;

    // Width of one routing entry: {valid, source slot, source subchannel}.
    function automatic int entry_w(input int slot_w);
        return 1 + slot_w + SUB_W;
    endfunction
endpackage

// File: rtl/sbs_frame_store.sv
// Two-bank frame store with a slot counter.
// Writes each input slot into the current write bank. Presents the whole
// other bank as a flat bit vector, so any number of bits can be read in parallel.
// Assumes fsync marks slot 0. The count wraps after SLOTS-1 on its own.
module sbs_frame_store #(
    parameter int SLOTS  = 32,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fsync,
    input  logic [7:0]            in_data,
    output logic [SLOT_W-1:0]     cur_slot,
    output logic [SLOTS*8-1:0]    rd_bits,
    output logic                  bank_q,
    output logic [SLOT_W-1:0]     slot_q
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    logic [SLOTS*8-1:0] bank0_q, bank1_q;
    logic               wr_bank;

    // Select the slot and write bank in effect for this cycle.
    always_comb begin
        cur_slot = fsync ? '0 : slot_q;
        wr_bank  = fsync ? ~bank_q : bank_q;
        rd_bits  = wr_bank ? bank0_q : bank1_q;
    end

    // Store the slot byte, advance the slot and remember the bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank0_q <= '0;
            bank1_q <= '0;
            bank_q  <= 1'b0;
            slot_q  <= '0;
        end else begin
            bank_q <= wr_bank;
            slot_q <= (cur_slot == LAST) ? '0 : cur_slot + 1'b1;
            if (wr_bank) bank1_q[{cur_slot, 3'b000} +: 8] <= in_data;
            else         bank0_q[{cur_slot, 3'b000} +: 8] <= in_data;
        end
    end
endmodule

// File: rtl/sbs_conn_mem.sv
// Shadow and active routing tables.
// The control port writes the shadow table. The shadow is copied into the
// active table at each fsync. On the fsync cycle the lookup reads the shadow,
// so slot 0 of a new frame already uses the new routes.
// Assumes rd_slot < SLOTS.
module sbs_conn_mem #(
    parameter int SLOTS  = 32,
    parameter int SLOT_W = $clog2(SLOTS),
    parameter int EW     = sbs_pkg::entry_w(SLOT_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fsync,
    input  logic                  cfg_we,
    input  logic [SLOT_W+2:0]     cfg_addr,
    input  logic [EW-1:0]         cfg_entry,
    input  logic [SLOT_W-1:0]     rd_slot,
    output logic [8*EW-1:0]       look
);
    localparam int ENTRIES = SLOTS * sbs_pkg::SUBCH;
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    logic [EW-1:0] shadow_q [ENTRIES];
    logic [EW-1:0] active_q [ENTRIES];

    // Take shadow writes and copy the shadow to active at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                shadow_q[i] <= '0;
                active_q[i] <= '0;
            end
        end else begin
            if (fsync) begin
                for (int i = 0; i < ENTRIES; i++) active_q[i] <= shadow_q[i];
            end
            if (cfg_we && (cfg_addr[SLOT_W+2:3] <= LAST))
                shadow_q[cfg_addr] <= cfg_entry;
        end
    end

    for (genvar c = 0; c < sbs_pkg::SUBCH; c++) begin : g_look
        // Fetch the entry for subchannel c of the slot being built.
        always_comb begin
            look[c*EW +: EW] = fsync ? shadow_q[{rd_slot, 3'(c)}]
                                     : active_q[{rd_slot, 3'(c)}];
        end
    end
endmodule

// File: rtl/sbs_gather.sv
// Builds one output byte from eight routing entries and the stored frame.
// An invalid entry, or one whose source slot is out of range, yields 1.
// Output subchannel c goes to byte bit 7-c.
module sbs_gather #(
    parameter int SLOTS  = 32,
    parameter int SLOT_W = $clog2(SLOTS),
    parameter int EW     = sbs_pkg::entry_w(SLOT_W)
) (
    input  logic [SLOTS*8-1:0] rd_bits,
    input  logic [8*EW-1:0]    look,
    output logic [7:0]         byte_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    for (genvar c = 0; c < sbs_pkg::SUBCH; c++) begin : g_bit
        logic [EW-1:0]     ent;
        logic [SLOT_W-1:0] src_slot;
        logic [2:0]        src_sub;
        assign ent      = look[c*EW +: EW];
        assign src_slot = ent[SLOT_W+2:3];
        assign src_sub  = ent[2:0];
        // Pick the routed source bit, or idle-high.
        assign byte_o[7-c] = (ent[EW-1] && (src_slot <= LAST))
                           ? rd_bits[{src_slot, 3'd7 - src_sub}] : 1'b1;
    end
endmodule

// File: rtl/subrate_bit_switch.sv
// Top of the subrate bit-level TDM switch.
// One byte slot per clock. Output slot s of a frame is built from the
// previous input frame and registered one cycle after input slot s.
// Assumes SLOTS >= 2 and an fsync every SLOTS cycles in normal use.
module subrate_bit_switch #(
    parameter int SLOTS = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic [7:0]        in_data,
    input  logic              cfg_we,
    input  logic [SLOT_W+2:0] cfg_addr,
    input  logic              cfg_valid,
    input  logic [SLOT_W-1:0] cfg_src_slot,
    input  logic [2:0]        cfg_src_sub,
    output logic [7:0]        out_data,
    output logic              out_fsync
);
    localparam int EW = sbs_pkg::entry_w(SLOT_W);

    logic [SLOT_W-1:0]  cur_slot;
    logic [SLOTS*8-1:0] rd_bits;
    logic               bank_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [8*EW-1:0]    look;
    logic [7:0]         built;
    logic [EW-1:0]      cfg_entry;

    assign cfg_entry = {cfg_valid, cfg_src_slot, cfg_src_sub};

    sbs_frame_store #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .in_data(in_data),
        .cur_slot(cur_slot), .rd_bits(rd_bits), .bank_q(bank_q), .slot_q(slot_q)
    );

    sbs_conn_mem #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .EW(EW)) u_conn (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_entry(cfg_entry), .rd_slot(cur_slot), .look(look)
    );

    sbs_gather #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .EW(EW)) u_gather (
        .rd_bits(rd_bits), .look(look), .byte_o(built)
    );

    // Register the built byte and the frame marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= 8'hFF;
            out_fsync <= 1'b0;
        end else begin
            out_data  <= built;
            out_fsync <= fsync;
        end
    end
endmodule

// File: rtl/sbs_checker.sv
// Temporal checks on the frame sequencing of subrate_bit_switch.
// Bound to the top. Observes the frame pulse, the output marker, the
// write-bank flag and the registered slot count.
module sbs_checker #(
    parameter int SLOTS = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fsync,
    input logic              out_fsync,
    input logic              bank_q,
    input logic [SLOT_W-1:0] slot_q
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    assert_bank_swap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (bank_q != $past(bank_q)));
    assert_bank_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fsync |=> (bank_q == $past(bank_q)));
    assert_marker_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> out_fsync);
    assert_marker_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fsync |=> !out_fsync);
    assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= LAST);
    assert_slot_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (slot_q == SLOT_W'(1)));
endmodule

bind subrate_bit_switch sbs_checker #(.SLOTS(SLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .out_fsync(out_fsync),
    .bank_q(bank_q), .slot_q(slot_q)
);

// File: tb/subrate_bit_switch_bench.sv
// Self-checking bench: a reference model of the two tables and two frames,
// random data and routes from a fixed seed, and directed boundary cases.
module subrate_bit_switch_bench;
    localparam int SLOTS = 24;
    localparam int SW    = $clog2(SLOTS);
    localparam int NENT  = SLOTS * 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fsync;
    logic [7:0]    in_data;
    logic          cfg_we;
    logic [SW+2:0] cfg_addr;
    logic          cfg_valid;
    logic [SW-1:0] cfg_src_slot;
    logic [2:0]    cfg_src_sub;
    logic [7:0]    out_data;
    logic          out_fsync;

    always #2 clk = ~clk;

    subrate_bit_switch #(.SLOTS(SLOTS)) u_subrate_bit_switch (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .in_data(in_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_valid(cfg_valid),
        .cfg_src_slot(cfg_src_slot), .cfg_src_sub(cfg_src_sub),
        .out_data(out_data), .out_fsync(out_fsync)
    );

    int n_tests = 0;
    int n_fail  = 0;
    string req  = "R1";

    // Reference state.
    logic [7:0] m_cur  [SLOTS];
    logic [7:0] m_prev [SLOTS];
    bit sh_v [NENT]; int sh_s [NENT]; int sh_c [NENT];
    bit ac_v [NENT]; int ac_s [NENT]; int ac_c [NENT];
    int m_slot = 0;
    bit have_exp = 0;
    logic [7:0] exp_data;
    bit exp_fs;

    // Pending directed route writes.
    int q_n = 0;
    int q_a [64]; bit q_v [64]; int q_s [64]; int q_c [64];

    function automatic logic [7:0] model_byte(input int s);
        logic [7:0] r;
        for (int c = 0; c < 8; c++) begin
            int i = s * 8 + c;
            if (ac_v[i] && ac_s[i] < SLOTS) r[7-c] = m_prev[ac_s[i]][7-ac_c[i]];
            else                            r[7-c] = 1'b1;
        end
        return r;
    endfunction

    task automatic check_out();
        if (have_exp) begin
            n_tests++;
            if (out_data !== exp_data || out_fsync !== exp_fs) begin
                n_fail++;
                $display("FAIL %s: out_data=%h out_fsync=%b expected %h %b",
                         req, out_data, out_fsync, exp_data, exp_fs);
            end
        end
    endtask

    task automatic step(input bit fs, input logic [7:0] d, input bit we,
                        input int a, input bit v, input int ss, input int sc);
        int s;
        @(negedge clk);
        check_out();
        fsync = fs; in_data = d; cfg_we = we;
        cfg_addr = (SW+3)'(a); cfg_valid = v;
        cfg_src_slot = SW'(ss); cfg_src_sub = 3'(sc);
        s = fs ? 0 : m_slot;
        if (fs) begin
            for (int i = 0; i < SLOTS; i++) m_prev[i] = m_cur[i];
            for (int i = 0; i < NENT; i++) begin
                ac_v[i] = sh_v[i]; ac_s[i] = sh_s[i]; ac_c[i] = sh_c[i];
            end
        end
        exp_data = model_byte(s);
        exp_fs   = fs;
        have_exp = 1;
        m_cur[s] = d;
        if (we && a < NENT) begin
            sh_v[a] = v; sh_s[a] = ss; sh_c[a] = sc;
        end
        m_slot = (s == SLOTS - 1) ? 0 : s + 1;
    endtask

    task automatic push_route(input int a, input bit v, input int ss, input int sc);
        q_a[q_n] = a; q_v[q_n] = v; q_s[q_n] = ss; q_c[q_n] = sc; q_n++;
    endtask

    // One frame. Queued writes go out first, one per cycle, then random writes.
    task automatic run_frame(input bit sync, input bit rnd, input bit write_on_sync);
        for (int s = 0; s < SLOTS; s++) begin
            bit fs = sync && (s == 0);
            logic [7:0] d = 8'($urandom);
            if (q_n > 0 && (!fs || write_on_sync)) begin
                step(fs, d, 1'b1, q_a[0], q_v[0], q_s[0], q_c[0]);
                for (int k = 1; k < q_n; k++) begin
                    q_a[k-1] = q_a[k]; q_v[k-1] = q_v[k];
                    q_s[k-1] = q_s[k]; q_c[k-1] = q_c[k];
                end
                q_n--;
            end else if (rnd && ($urandom % 3 == 0)) begin
                step(fs, d, 1'b1, int'($urandom % (1 << (SW + 3))),
                     bit'($urandom % 4 != 0), int'($urandom % (1 << SW)),
                     int'($urandom % 8));
            end else begin
                step(fs, d, 1'b0, 0, 1'b0, 0, 0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < SLOTS; i++) begin m_cur[i] = '0; m_prev[i] = '0; end
        for (int i = 0; i < NENT; i++) begin
            sh_v[i] = 0; sh_s[i] = 0; sh_c[i] = 0;
            ac_v[i] = 0; ac_s[i] = 0; ac_c[i] = 0;
        end
        rst_n = 1'b0; fsync = 1'b0; in_data = '0; cfg_we = 1'b0;
        cfg_addr = '0; cfg_valid = 1'b0; cfg_src_slot = '0; cfg_src_sub = '0;
        repeat (3) @(negedge clk);
        // R1: reset values.
        n_tests++;
        if (out_data !== 8'hFF || out_fsync !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: out_data=%h out_fsync=%b expected ff 0", out_data, out_fsync);
        end
        rst_n = 1'b1;

        // R1 R7: no routes yet, so every subchannel idles high.
        req = "R1 R7";
        run_frame(1, 0, 0); run_frame(1, 0, 0);

        // R6: out slot 0 sub 0 <- in slot 3 sub 0; out slot 1 sub 7 <- in slot 3 sub 7.
        req = "R6";
        push_route(0, 1, 3, 0);
        push_route(1*8+7, 1, 3, 7);
        run_frame(1, 0, 0); run_frame(1, 0, 0); run_frame(1, 0, 0);

        // R10: 12-subchannel group from in slot 20 sub 4 to out slot 5 sub 0, over a slot edge.
        req = "R10";
        for (int k = 0; k < 12; k++)
            push_route(5*8 + k, 1, 20 + (4 + k) / 8, (4 + k) % 8);
        run_frame(1, 0, 0); run_frame(1, 0, 0); run_frame(1, 0, 0);

        // R9: a route written on the fsync cycle, and one on the last slot before it.
        req = "R9";
        push_route(2*8+3, 1, 7, 5);
        run_frame(1, 0, 1);
        for (int s = 0; s < SLOTS - 1; s++) step(s == 0, 8'($urandom), 1'b0, 0, 1'b0, 0, 0);
        step(1'b0, 8'($urandom), 1'b1, 3*8+1, 1'b1, 9, 2);
        run_frame(1, 0, 0); run_frame(1, 0, 0);

        // R7: source slot beyond SLOTS; R8: write with an out-of-range address is ignored.
        req = "R7 R8";
        push_route(4*8+0, 1, SLOTS + 3, 1);
        push_route(SLOTS*8 + 2, 1, 1, 1);
        run_frame(1, 0, 0); run_frame(1, 0, 0);

        // R4 R5: random routes with fan-out and random data.
        req = "R4 R5";
        for (int f = 0; f < 10; f++) run_frame(1, 1, 1);

        // R2: one frame with no fsync, so the count wraps and the banks stay put.
        req = "R2";
        run_frame(0, 0, 0);
        run_frame(1, 0, 0); run_frame(1, 0, 0);

        @(negedge clk);
        check_out();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule